// File: doc/BRIEF.md
# Tag-Clean-to-Deep-Persistence Access Trap Checker

This block decides what happens to a single cache-maintenance system instruction: the one that cleans allocation tags by address toward the deepest persistence point. For each request the decode stage presents the five encoding fields. Alongside them come the current exception level, the implemented-feature flags and the control bits that govern trapping. The block matches the encoding, checks that the instruction exists, and walks a fixed-priority chain of trap conditions. The result is one of five verdicts.

The verdict leaves through one register stage, together with the trap target level and the syndrome exception class. On execute it also carries a scope code that says how far the clean must reach. The block does no address translation, no cache work, no fault generation and no syndrome-register write. It accepts at most one request per cycle.

Top module: `sysop_trap_check`

## Requirements
- R1: A request matches only for op0=2'b01, op1=3'b011, CRn=4'b0111, CRm=4'b1101 and op2=3'b011. Any other encoding gives verdict code 0 (no match), with target level 0, syndrome 0 and scope 0. Verdict codes are: 0 no match, 1 execute, 2 trap to EL1, 3 trap to EL2, 4 undefined.
- R2: A matching request gives verdict 4 (undefined) when either the persistence-clean feature flag or the tag-memory feature flag is 0, at any exception level.
- R3: At EL0 outside host mode, with the EL1 user cache-op enable at 0, the request traps. It goes to EL2 when EL2 is enabled and the trap-general bit is 1, and to EL1 otherwise. This check has the highest priority at EL0.
- R4: At EL0 outside host mode, or at EL1, a set hypervisor cache-maintenance trap bit with EL2 enabled traps to EL2. This check comes after R3.
- R5: After R4, a fine-grained trap goes to EL2 when all of these hold: EL2 is enabled, the fine-grained feature flag is 1, the instruction's fine-grained bit is 1, and either no EL3 is present or the EL3 fine-grained enable is 1.
- R6: At EL0 in host mode, only the EL2 user cache-op enable is tested: 0 traps to EL2 and 1 executes. R3 to R5 do not apply.
- R7: At EL2 and EL3 a matching, implemented request always executes (verdict 1).
- R8: Every trap reports syndrome class 6'h18 and target level 1 or 2 as its verdict names. Every non-trap result reports syndrome 0 and target 0.
- R9: On execute the scope code is 2'b10 (deep persistence) when the memory system reports a deep-persistence point, and 2'b01 (persistence) when it does not. The scope is 2'b00 for every other verdict.
- R10: res_valid is high exactly one cycle after req_valid is high. The result fields hold their value in cycles with no request.
- R11: A synchronous active-high reset clears res_valid and the result fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level |
| host_mode | input | 1 | EL0 is running under the hypervisor host |
| el2_enabled | input | 1 | EL2 is enabled in the current security state |
| el3_present | input | 1 | EL3 is implemented |
| feat_persist_clean | input | 1 | Deep-persistence clean feature implemented |
| feat_tag_mem | input | 1 | Tag memory feature implemented |
| feat_fine_trap | input | 1 | Fine-grained trap feature implemented |
| el1_user_cmo_en | input | 1 | EL1 enable for user cache operations |
| el2_user_cmo_en | input | 1 | EL2 (host) enable for user cache operations |
| hyp_tge | input | 1 | Hypervisor trap-general-exceptions bit |
| hyp_trap_cmo | input | 1 | Hypervisor cache-maintenance trap bit |
| fine_trap_bit | input | 1 | Fine-grained trap bit for this instruction |
| el3_fine_en | input | 1 | EL3 enable for fine-grained traps |
| deep_persist_present | input | 1 | Memory system has a deep-persistence point |
| res_valid | output | 1 | Result valid |
| res_verdict | output | 3 | Verdict code |
| res_target_el | output | 2 | Trap target exception level |
| res_syndrome | output | 6 | Syndrome exception class |
| res_scope | output | 2 | Clean scope code |

## Verification
The chain has no stored state beyond its single output register, so any fault in the priority logic shows at the ports on the cycle after the request that exposes it. A wrong branch appears as a wrong verdict, target level or syndrome. A fault in the output stage shows as res_valid out of step with req_valid, or as result fields that move with no request. A full sweep of exception level, host mode, every control bit and the deep-persistence flag reaches every branch. A missed priority or a swapped target therefore surfaces within one cycle of the combination that triggers it.

// File: rtl/sysop_trap_pkg.sv
package sysop_trap_pkg;

    localparam int EC_W = 6;

    typedef enum logic [2:0] {
        VERDICT_NOMATCH  = 3'd0,
        VERDICT_EXEC     = 3'd1,
        VERDICT_TRAP_EL1 = 3'd2,
        VERDICT_TRAP_EL2 = 3'd3,
        VERDICT_UNDEF    = 3'd4
    } verdict_e;

    typedef enum logic [1:0] {
        SCOPE_NONE    = 2'd0,
        SCOPE_PERSIST = 2'd1,
        SCOPE_DEEP    = 2'd2
    } scope_e;

    localparam logic [1:0] LVL_EL0 = 2'd0;
    localparam logic [1:0] LVL_EL1 = 2'd1;
    localparam logic [1:0] LVL_EL2 = 2'd2;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    typedef struct packed {
        logic host_mode;
        logic el2_enabled;
        logic el3_present;
        logic feat_persist_clean;
        logic feat_tag_mem;
        logic feat_fine_trap;
        logic el1_user_en;
        logic el2_user_en;
        logic hyp_tge;
        logic hyp_trap_cmo;
        logic fine_trap_bit;
        logic el3_fine_en;
    } trapctl_t;

    typedef struct packed {
        verdict_e        verdict;
        logic [1:0]      target_el;
        logic [EC_W-1:0] syndrome;
        scope_e          scope;
    } result_t;

    localparam sysenc_t TAG_CLEAN_DEEP_ENC = '{
        op0: 2'b01, op1: 3'b011, crn: 4'b0111, crm: 4'b1101, op2: 3'b011
    };

    function automatic logic fine_trap_armed(trapctl_t c);
        return c.el2_enabled && c.feat_fine_trap && c.fine_trap_bit &&
               (!c.el3_present || c.el3_fine_en);
    endfunction

    function automatic result_t make_trap(logic [1:0] lvl, logic [EC_W-1:0] ec);
        result_t r;
        r = '0;
        r.verdict   = (lvl == LVL_EL2) ? VERDICT_TRAP_EL2 : VERDICT_TRAP_EL1;
        r.target_el = lvl;
        r.syndrome  = ec;
        r.scope     = SCOPE_NONE;
        return r;
    endfunction

    function automatic result_t make_exec(logic deep);
        result_t r;
        r = '0;
        r.verdict = VERDICT_EXEC;
        r.scope   = deep ? SCOPE_DEEP : SCOPE_PERSIST;
        return r;
    endfunction

    function automatic result_t make_plain(verdict_e v);
        result_t r;
        r = '0;
        r.verdict = v;
        r.scope   = SCOPE_NONE;
        return r;
    endfunction

endpackage

// File: rtl/sysop_enc_match.sv
module sysop_enc_match
    import sysop_trap_pkg::*;
#(
    parameter sysenc_t TARGET = TAG_CLEAN_DEEP_ENC
) (
    input  sysenc_t enc,
    output logic    hit
);
    logic [4:0] field_eq;

    always_comb begin
        field_eq[0] = (enc.op0 == TARGET.op0);
        field_eq[1] = (enc.op1 == TARGET.op1);
        field_eq[2] = (enc.crn == TARGET.crn);
        field_eq[3] = (enc.crm == TARGET.crm);
        field_eq[4] = (enc.op2 == TARGET.op2);
    end

    assign hit = &field_eq;
endmodule

// File: rtl/sysop_trap_chain.sv
module sysop_trap_chain
    import sysop_trap_pkg::*;
#(
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic       hit,
    input  logic [1:0] el,
    input  trapctl_t   ctl,
    input  logic       deep_present,
    output result_t    res
);
    logic present;
    logic hyp_cmo_trap;
    logic fine_trap;
    logic [1:0] user_trap_lvl;

    always_comb begin
        present       = ctl.feat_persist_clean && ctl.feat_tag_mem;
        hyp_cmo_trap  = ctl.el2_enabled && ctl.hyp_trap_cmo;
        fine_trap     = fine_trap_armed(ctl);
        user_trap_lvl = (ctl.el2_enabled && ctl.hyp_tge) ? LVL_EL2 : LVL_EL1;
    end

    always_comb begin
        res = make_plain(VERDICT_NOMATCH);
        if (!hit) begin
            res = make_plain(VERDICT_NOMATCH);
        end else if (!present) begin
            res = make_plain(VERDICT_UNDEF);
        end else begin
            unique case (el)
                LVL_EL0: begin
                    if (ctl.host_mode) begin
                        if (!ctl.el2_user_en) res = make_trap(LVL_EL2, TRAP_EC);
                        else                  res = make_exec(deep_present);
                    end else if (!ctl.el1_user_en) begin
                        res = make_trap(user_trap_lvl, TRAP_EC);
                    end else if (hyp_cmo_trap) begin
                        res = make_trap(LVL_EL2, TRAP_EC);
                    end else if (fine_trap) begin
                        res = make_trap(LVL_EL2, TRAP_EC);
                    end else begin
                        res = make_exec(deep_present);
                    end
                end
                LVL_EL1: begin
                    if (hyp_cmo_trap)   res = make_trap(LVL_EL2, TRAP_EC);
                    else if (fine_trap) res = make_trap(LVL_EL2, TRAP_EC);
                    else                res = make_exec(deep_present);
                end
                default: res = make_exec(deep_present);
            endcase
        end
    end
endmodule

// File: rtl/sysop_result_stage.sv
module sysop_result_stage
    import sysop_trap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  result_t in_res,
    output logic    out_valid,
    output result_t out_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_res <= in_res;
        end
    end
endmodule

// File: rtl/sysop_trap_check.sv
module sysop_trap_check
    import sysop_trap_pkg::*;
#(
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_op0,
    input  logic [2:0]      req_op1,
    input  logic [3:0]      req_crn,
    input  logic [3:0]      req_crm,
    input  logic [2:0]      req_op2,
    input  logic [1:0]      cur_el,
    input  logic            host_mode,
    input  logic            el2_enabled,
    input  logic            el3_present,
    input  logic            feat_persist_clean,
    input  logic            feat_tag_mem,
    input  logic            feat_fine_trap,
    input  logic            el1_user_cmo_en,
    input  logic            el2_user_cmo_en,
    input  logic            hyp_tge,
    input  logic            hyp_trap_cmo,
    input  logic            fine_trap_bit,
    input  logic            el3_fine_en,
    input  logic            deep_persist_present,
    output logic            res_valid,
    output logic [2:0]      res_verdict,
    output logic [1:0]      res_target_el,
    output logic [EC_W-1:0] res_syndrome,
    output logic [1:0]      res_scope
);
    sysenc_t  enc;
    trapctl_t ctl;
    logic     hit;
    result_t  comb_res;
    result_t  reg_res;

    always_comb begin
        enc.op0 = req_op0;
        enc.op1 = req_op1;
        enc.crn = req_crn;
        enc.crm = req_crm;
        enc.op2 = req_op2;
        ctl.host_mode          = host_mode;
        ctl.el2_enabled        = el2_enabled;
        ctl.el3_present        = el3_present;
        ctl.feat_persist_clean = feat_persist_clean;
        ctl.feat_tag_mem       = feat_tag_mem;
        ctl.feat_fine_trap     = feat_fine_trap;
        ctl.el1_user_en        = el1_user_cmo_en;
        ctl.el2_user_en        = el2_user_cmo_en;
        ctl.hyp_tge            = hyp_tge;
        ctl.hyp_trap_cmo       = hyp_trap_cmo;
        ctl.fine_trap_bit      = fine_trap_bit;
        ctl.el3_fine_en        = el3_fine_en;
    end

    sysop_enc_match #(.TARGET(TAG_CLEAN_DEEP_ENC)) u_match (
        .enc (enc),
        .hit (hit)
    );

    sysop_trap_chain #(.TRAP_EC(TRAP_EC)) u_chain (
        .hit          (hit),
        .el           (cur_el),
        .ctl          (ctl),
        .deep_present (deep_persist_present),
        .res          (comb_res)
    );

    sysop_result_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_res    (comb_res),
        .out_valid (res_valid),
        .out_res   (reg_res)
    );

    assign res_verdict   = reg_res.verdict;
    assign res_target_el = reg_res.target_el;
    assign res_syndrome  = reg_res.syndrome;
    assign res_scope     = reg_res.scope;
endmodule

// File: rtl/sysop_trap_check_sva.sv
module sysop_trap_check_sva (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_op0,
    input logic [2:0] req_op1,
    input logic [3:0] req_crn,
    input logic [3:0] req_crm,
    input logic [2:0] req_op2,
    input logic [1:0] cur_el,
    input logic       host_mode,
    input logic       feat_persist_clean,
    input logic       feat_tag_mem,
    input logic       res_valid,
    input logic [2:0] res_verdict,
    input logic [1:0] res_target_el,
    input logic [5:0] res_syndrome,
    input logic [1:0] res_scope
);
    logic enc_ok;
    logic is_trap;
    assign enc_ok  = (req_op0 == 2'b01) && (req_op1 == 3'b011) && (req_crn == 4'b0111) &&
                     (req_crm == 4'b1101) && (req_op2 == 3'b011);
    assign is_trap = (res_verdict == 3'd2) || (res_verdict == 3'd3);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(res_verdict) && $stable(res_scope)); // R10
    AST_NOMATCH_CODE: assert property (@(posedge clk) disable iff (rst)
        req_valid && !enc_ok |=> res_verdict == 3'd0); // R1
    AST_MISSING_FEATURE: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_ok && !(feat_persist_clean && feat_tag_mem) |=> res_verdict == 3'd4); // R2
    AST_HOST_TARGET: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_ok && feat_persist_clean && feat_tag_mem && cur_el == 2'd0 && host_mode
        |=> res_verdict == 3'd1 || res_verdict == 3'd3); // R6
    AST_HIGH_EL_EXEC: assert property (@(posedge clk) disable iff (rst)
        req_valid && enc_ok && feat_persist_clean && feat_tag_mem && cur_el[1]
        |=> res_verdict == 3'd1); // R7
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        res_valid && is_trap |-> res_syndrome == 6'h18 && res_target_el == res_verdict[1:0] - 2'd1); // R8
    AST_QUIET_CLASS: assert property (@(posedge clk) disable iff (rst)
        res_valid && !is_trap |-> res_syndrome == 6'h0 && res_target_el == 2'd0); // R8
    AST_SCOPE_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_verdict != 3'd1 |-> res_scope == 2'd0); // R9
    AST_SCOPE_ON_EXEC: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_verdict == 3'd1 |-> $onehot0(res_scope) && res_scope != 2'd0); // R9
endmodule

bind sysop_trap_check sysop_trap_check_sva u_sva (.*);

// File: tb/sysop_trap_check_test.sv
module sysop_trap_check_test;
    import sysop_trap_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, req_valid, deep;
    logic [1:0] op0, el;
    logic [2:0] op1, op2;
    logic [3:0] crn, crm;
    trapctl_t drv;
    logic res_valid;
    logic [2:0] res_verdict;
    logic [1:0] res_target_el, res_scope;
    logic [5:0] res_syndrome;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    sysop_trap_check uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_op0(op0), .req_op1(op1), .req_crn(crn), .req_crm(crm), .req_op2(op2),
        .cur_el(el), .host_mode(drv.host_mode), .el2_enabled(drv.el2_enabled),
        .el3_present(drv.el3_present), .feat_persist_clean(drv.feat_persist_clean),
        .feat_tag_mem(drv.feat_tag_mem), .feat_fine_trap(drv.feat_fine_trap),
        .el1_user_cmo_en(drv.el1_user_en), .el2_user_cmo_en(drv.el2_user_en),
        .hyp_tge(drv.hyp_tge), .hyp_trap_cmo(drv.hyp_trap_cmo),
        .fine_trap_bit(drv.fine_trap_bit), .el3_fine_en(drv.el3_fine_en),
        .deep_persist_present(deep),
        .res_valid(res_valid), .res_verdict(res_verdict), .res_target_el(res_target_el),
        .res_syndrome(res_syndrome), .res_scope(res_scope)
    );

    // {el[1:0], host, el2en, el3p, fpc, ftag, ffgt, uce1, uce2, tge, tcmo, fgbit, el3fg, deep, verdict[2:0]}
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        18'b00_000_110_000000_0_010,   // R3 user enable off, no EL2 -> EL1
        18'b00_010_110_001000_0_011,   // R3 user enable off, TGE -> EL2
        18'b00_010_110_100100_0_011,   // R4 hyp cmo trap at EL0
        18'b00_010_111_100010_0_011,   // R5 fine trap, no EL3
        18'b00_011_111_100010_1_001,   // R5 fine trap blocked by EL3 enable
        18'b01_010_110_000100_0_011,   // R4 hyp cmo trap at EL1
        18'b01_000_110_000000_0_001,   // R9 EL1 execute, persistence scope
        18'b00_110_110_110100_1_001,   // R6 host mode ignores hyp cmo trap
        18'b10_000_100_000000_0_100,   // R2 tag feature missing
        18'b11_010_110_000100_0_001    // R7 EL3 executes
    };

    function automatic logic [2:0] ref_verdict(logic [1:0] lvl, trapctl_t c);
        logic exists, fg, hyp;
        exists = c.feat_persist_clean & c.feat_tag_mem;
        fg     = c.el2_enabled & c.feat_fine_trap & c.fine_trap_bit & (~c.el3_present | c.el3_fine_en);
        hyp    = c.el2_enabled & c.hyp_trap_cmo;
        if (!exists) return 3'd4;
        if (lvl >= 2'd2) return 3'd1;
        if (lvl == 2'd0 && c.host_mode) return c.el2_user_en ? 3'd1 : 3'd3;
        if (lvl == 2'd0 && !c.el1_user_en) return (c.el2_enabled & c.hyp_tge) ? 3'd3 : 3'd2;
        if (hyp || fg) return 3'd3;
        return 3'd1;
    endfunction

    task automatic check_res(input logic [2:0] v, input logic dp, input string req);
        logic [1:0] exp_t;
        logic [5:0] exp_ec;
        logic [1:0] exp_s;
        exp_t  = (v == 3'd2) ? 2'd1 : (v == 3'd3) ? 2'd2 : 2'd0;
        exp_ec = (v == 3'd2 || v == 3'd3) ? 6'h18 : 6'h0;
        exp_s  = (v == 3'd1) ? (dp ? 2'd2 : 2'd1) : 2'd0;
        checks++;
        if (res_valid !== 1'b1 || res_verdict !== v || res_target_el !== exp_t ||
            res_syndrome !== exp_ec || res_scope !== exp_s) begin
            failures++;
            $display("FAIL %s: got v=%0b verdict=%0d tgt=%0d ec=%h scope=%0d exp verdict=%0d tgt=%0d ec=%h scope=%0d",
                     req, res_valid, res_verdict, res_target_el, res_syndrome, res_scope,
                     v, exp_t, exp_ec, exp_s);
        end
    endtask

    task automatic set_match();
        op0 = 2'b01; op1 = 3'b011; crn = 4'b0111; crm = 4'b1101; op2 = 3'b011;
    endtask

    // Called at a falling edge; drives, waits one cycle, samples at the next falling edge.
    task automatic apply(input logic [1:0] lvl, input trapctl_t c, input logic dp);
        req_valid = 1'b1; el = lvl; drv = c; deep = dp;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; el = 2'd0; drv = '0; deep = 1'b0;
        set_match();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_verdict !== 3'd0 || res_scope !== 2'd0) begin
            failures++;
            $display("FAIL R11 reset: got v=%0b verdict=%0d exp v=0 verdict=0", res_valid, res_verdict);
        end

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:16], trapctl_t'(VEC[i][15:4]), VEC[i][3]);
            check_res(VEC[i][2:0], VEC[i][3], "R3-chain table (R2 R3 R4 R5 R6 R7 R9)");
        end

        for (int i = 0; i < (1 << 15); i++) begin
            logic [14:0] b;
            b = i[14:0];
            apply(b[1:0], trapctl_t'(b[13:2]), b[14]);
            check_res(ref_verdict(b[1:0], trapctl_t'(b[13:2])), b[14], "sweep R2 R3 R4 R5 R6 R7 R8 R9");
        end

        drv = '0; drv.feat_persist_clean = 1'b1; drv.feat_tag_mem = 1'b1;
        op2 = 3'b001;
        apply(2'd0, drv, 1'b1);
        check_res(3'd0, 1'b1, "R1 op2 mismatch");
        set_match(); crm = 4'b1100;
        apply(2'd3, drv, 1'b1);
        check_res(3'd0, 1'b1, "R1 CRm mismatch");
        set_match(); op0 = 2'b11;
        drv.feat_tag_mem = 1'b0;
        apply(2'd1, drv, 1'b0);
        check_res(3'd0, 1'b0, "R1 mismatch beats missing feature");
        set_match();

        drv.feat_tag_mem = 1'b1;
        apply(2'd2, drv, 1'b1);
        check_res(3'd1, 1'b1, "R10 setup");
        req_valid = 1'b0; el = 2'd0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_verdict !== 3'd1 || res_scope !== 2'd2) begin
            failures++;
            $display("FAIL R10 idle hold: got v=%0b verdict=%0d scope=%0d exp v=0 verdict=1 scope=2",
                     res_valid, res_verdict, res_scope);
        end

        apply(2'd0, drv, 1'b0);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (res_valid !== 1'b0 || res_verdict !== 3'd0) begin
            failures++;
            $display("FAIL R11 mid reset: got v=%0b verdict=%0d exp v=0 verdict=0", res_valid, res_verdict);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule